// File: doc/BRIEF.md
# Automatic Transmit/Receive Pin Switcher

This block drives four banks of 16 general-purpose pins that lead to plug-in radio boards. While automatic switching is enabled, each pin chosen by a per-bank mask follows one of two programmed patterns. The transmit pattern applies while the transmit FIFO holds samples. The receive pattern applies at all other times. Pins outside the mask, and every pin while switching is disabled, keep the value from the ordinary pin output register.

The FIFO occupancy flag is not used directly. It feeds a transmit/receive indication built by a four-state machine. The states are `TR_RX` (receive), `TR_RISE_WAIT` (counting toward transmit), `TR_TX` (transmit) and `TR_FALL_WAIT` (counting toward receive). Its transitions are:
- `TR_RX` moves to `TR_TX` when the FIFO is non-empty and the rise delay is zero, and to `TR_RISE_WAIT` when the rise delay is non-zero.
- `TR_RISE_WAIT` moves to `TR_TX` once its count reaches the rise delay, and back to `TR_RX` (cancel) if the FIFO empties first.
- `TR_TX` moves to `TR_RX` when the FIFO is empty and the fall delay is zero, and to `TR_FALL_WAIT` when the fall delay is non-zero.
- `TR_FALL_WAIT` moves to `TR_RX` once its count reaches the fall delay, and back to `TR_TX` (cancel) if the FIFO refills first.

The indication reads high in `TR_TX` and `TR_FALL_WAIT`. The pin values are registered, so every output bit comes straight from a flip-flop.

Top module: `atr_switch`

## Requirements
- R1: While reset is asserted, the indication is in receive, every mask, pattern and delay register reads 0, and `pin_out` is 0.
- R2: When `atr_en` was 0 at a clock edge, `pin_out` after that edge equals the `normal_out` sampled at that edge.
- R3: Writes are decoded on a 5-bit address. For bank s (0..3), the mask is at 20+3s, the transmit pattern at 21+3s and the receive pattern at 22+3s. The rise delay is at 2 and the fall delay is at 3. Writes to any other address change no pin.
- R4: A pin whose mask bit is 0 takes the `normal_out` bit sampled at the previous edge.
- R5: With `atr_en` set, a masked pin takes the transmit pattern bit while the indication is transmit, and the receive pattern bit otherwise.
- R6: If `fifo_nonempty` is first sampled high at edge k while in receive and stays high, the indication becomes transmit at edge k+D, where D is the rise delay. D=0 switches at edge k itself.
- R7: If `fifo_nonempty` is first sampled low at edge k while in transmit and stays low, the indication returns to receive at edge k+F, where F is the fall delay.
- R8: If the FIFO flag reverts before a pending delay expires, the pending switch is dropped. A later change starts a fresh count.
- R9: `pin_out` is registered and reflects the indication, registers and inputs as they stood one edge earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| atr_en | input | 1 | Enables automatic switching |
| fifo_nonempty | input | 1 | Transmit FIFO holds data |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register write address |
| reg_wdata | input | 16 | Register write data |
| normal_out | input | 64 | Ordinary pin values, bank s in bits 16s+15:16s |
| pin_out | output | 64 | Final pin values, same bank layout |

## Verification
On every cycle, the assertions check three things: disabled switching passes `normal_out` through, unmasked bits follow `normal_out`, and the indication rises only after a non-empty FIFO sample and falls only after an empty one. The exact rise and fall latencies, the cancellation of a pending switch and the address decode are shown only by the bench's scenarios. For this it runs a cycle model alongside the design and adds directed latency counts.

// File: rtl/atr_pkg.sv
package atr_pkg;
    typedef enum logic [1:0] {
        TR_RX        = 2'd0,
        TR_RISE_WAIT = 2'd1,
        TR_TX        = 2'd2,
        TR_FALL_WAIT = 2'd3
    } tr_state_e;
endpackage

// File: rtl/atr_regs.sv
module atr_regs #(
    parameter int NUM_SLOTS = 4,
    parameter int PIN_W     = 16,
    parameter int ADDR_W    = 5,
    parameter int DLY_W     = 16,
    parameter int RISE_ADDR = 2,
    parameter int FALL_ADDR = 3,
    parameter int SLOT_BASE = 20
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr,
    input  logic [ADDR_W-1:0]          addr,
    input  logic [PIN_W-1:0]           wdata,
    output logic [NUM_SLOTS*PIN_W-1:0] mask_vec,
    output logic [NUM_SLOTS*PIN_W-1:0] txv_vec,
    output logic [NUM_SLOTS*PIN_W-1:0] rxv_vec,
    output logic [DLY_W-1:0]           rise_dly,
    output logic [DLY_W-1:0]           fall_dly
);
    localparam logic [ADDR_W-1:0] A_RISE = ADDR_W'(RISE_ADDR);
    localparam logic [ADDR_W-1:0] A_FALL = ADDR_W'(FALL_ADDR);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rise_dly <= '0;
            fall_dly <= '0;
        end else if (wr) begin
            if (addr == A_RISE) rise_dly <= wdata[DLY_W-1:0];
            if (addr == A_FALL) fall_dly <= wdata[DLY_W-1:0];
        end
    end

    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
        localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(SLOT_BASE + 3*s);
        localparam logic [ADDR_W-1:0] A_TXV  = ADDR_W'(SLOT_BASE + 3*s + 1);
        localparam logic [ADDR_W-1:0] A_RXV  = ADDR_W'(SLOT_BASE + 3*s + 2);
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                mask_vec[s*PIN_W +: PIN_W] <= '0;
                txv_vec[s*PIN_W +: PIN_W]  <= '0;
                rxv_vec[s*PIN_W +: PIN_W]  <= '0;
            end else if (wr) begin
                if (addr == A_MASK) mask_vec[s*PIN_W +: PIN_W] <= wdata;
                if (addr == A_TXV)  txv_vec[s*PIN_W +: PIN_W]  <= wdata;
                if (addr == A_RXV)  rxv_vec[s*PIN_W +: PIN_W]  <= wdata;
            end
        end
    end
endmodule

// File: rtl/atr_tr_fsm.sv
module atr_tr_fsm
    import atr_pkg::*;
#(
    parameter int DLY_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fifo_ne,
    input  logic [DLY_W-1:0] rise_dly,
    input  logic [DLY_W-1:0] fall_dly,
    output logic             tr
);
    tr_state_e        state, state_n;
    logic [DLY_W-1:0] cnt, cnt_n;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= TR_RX;
            cnt   <= '0;
        end else begin
            state <= state_n;
            cnt   <= cnt_n;
        end
    end

    // Next state, counter and indication
    always_comb begin
        state_n = state;
        cnt_n   = cnt;
        unique case (state)
            TR_RX: begin
                if (fifo_ne) begin
                    if (rise_dly == '0) state_n = TR_TX;
                    else begin
                        state_n = TR_RISE_WAIT;
                        cnt_n   = DLY_W'(1);
                    end
                end
            end
            TR_RISE_WAIT: begin
                if (!fifo_ne)             state_n = TR_RX;
                else if (cnt >= rise_dly) state_n = TR_TX;
                else                      cnt_n   = cnt + 1'b1;
            end
            TR_TX: begin
                if (!fifo_ne) begin
                    if (fall_dly == '0) state_n = TR_RX;
                    else begin
                        state_n = TR_FALL_WAIT;
                        cnt_n   = DLY_W'(1);
                    end
                end
            end
            TR_FALL_WAIT: begin
                if (fifo_ne)              state_n = TR_TX;
                else if (cnt >= fall_dly) state_n = TR_RX;
                else                      cnt_n   = cnt + 1'b1;
            end
            default: state_n = TR_RX;
        endcase
        tr = (state == TR_TX) || (state == TR_FALL_WAIT);
    end
endmodule

// File: rtl/atr_pin_mux.sv
module atr_pin_mux #(
    parameter int NUM_SLOTS = 4,
    parameter int PIN_W     = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       atr_en,
    input  logic                       tr,
    input  logic [NUM_SLOTS*PIN_W-1:0] normal_vec,
    input  logic [NUM_SLOTS*PIN_W-1:0] mask_vec,
    input  logic [NUM_SLOTS*PIN_W-1:0] txv_vec,
    input  logic [NUM_SLOTS*PIN_W-1:0] rxv_vec,
    output logic [NUM_SLOTS*PIN_W-1:0] pin_q
);
    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_bank
        logic [PIN_W-1:0] sel, msk, nrm;
        always_comb begin
            sel = tr ? txv_vec[s*PIN_W +: PIN_W] : rxv_vec[s*PIN_W +: PIN_W];
            msk = atr_en ? mask_vec[s*PIN_W +: PIN_W] : '0;
            nrm = normal_vec[s*PIN_W +: PIN_W];
        end
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pin_q[s*PIN_W +: PIN_W] <= '0;
            else        pin_q[s*PIN_W +: PIN_W] <= (nrm & ~msk) | (sel & msk);
        end
    end
endmodule

// File: rtl/atr_switch.sv
module atr_switch #(
    parameter int NUM_SLOTS = 4,
    parameter int PIN_W     = 16,
    parameter int ADDR_W    = 5,
    parameter int DLY_W     = 16,
    parameter int RISE_ADDR = 2,
    parameter int FALL_ADDR = 3,
    parameter int SLOT_BASE = 20
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       atr_en,
    input  logic                       fifo_nonempty,
    input  logic                       reg_wr,
    input  logic [ADDR_W-1:0]          reg_addr,
    input  logic [PIN_W-1:0]           reg_wdata,
    input  logic [NUM_SLOTS*PIN_W-1:0] normal_out,
    output logic [NUM_SLOTS*PIN_W-1:0] pin_out
);
    localparam int BUS_W = NUM_SLOTS * PIN_W;

    logic [BUS_W-1:0] mask_vec, txv_vec, rxv_vec;
    logic [DLY_W-1:0] rise_dly, fall_dly;
    logic             tr_ind;

    atr_regs #(
        .NUM_SLOTS(NUM_SLOTS), .PIN_W(PIN_W), .ADDR_W(ADDR_W), .DLY_W(DLY_W),
        .RISE_ADDR(RISE_ADDR), .FALL_ADDR(FALL_ADDR), .SLOT_BASE(SLOT_BASE)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
        .mask_vec(mask_vec), .txv_vec(txv_vec), .rxv_vec(rxv_vec),
        .rise_dly(rise_dly), .fall_dly(fall_dly)
    );

    atr_tr_fsm #(.DLY_W(DLY_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .fifo_ne(fifo_nonempty),
        .rise_dly(rise_dly), .fall_dly(fall_dly), .tr(tr_ind)
    );

    atr_pin_mux #(.NUM_SLOTS(NUM_SLOTS), .PIN_W(PIN_W)) u_mux (
        .clk(clk), .rst_n(rst_n), .atr_en(atr_en), .tr(tr_ind),
        .normal_vec(normal_out), .mask_vec(mask_vec), .txv_vec(txv_vec),
        .rxv_vec(rxv_vec), .pin_q(pin_out)
    );
endmodule

// File: rtl/atr_switch_chk.sv
module atr_switch_chk #(
    parameter int BUS_W = 64
) (
    input logic             clk,
    input logic             rst_n,
    input logic             atr_en,
    input logic             fifo_nonempty,
    input logic [BUS_W-1:0] normal_out,
    input logic [BUS_W-1:0] pin_out,
    input logic [BUS_W-1:0] mask_vec,
    input logic             tr_ind
);
    // R2
    disabled_passthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(atr_en)) |-> (pin_out == $past(normal_out)));

    // R4
    unmasked_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (((pin_out ^ $past(normal_out)) & ~$past(mask_vec)) == '0));

    // R6
    rise_needs_fifo_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $rose(tr_ind)) |-> $past(fifo_nonempty));

    // R7
    fall_needs_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $fell(tr_ind)) |-> !$past(fifo_nonempty));

    // R1
    always @(posedge clk) begin
        if (!rst_n) begin
            reset_state_chk: assert (!tr_ind && pin_out == '0 && mask_vec == '0);
        end
    end
endmodule

bind atr_switch atr_switch_chk #(.BUS_W(NUM_SLOTS*PIN_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .atr_en(atr_en), .fifo_nonempty(fifo_nonempty),
    .normal_out(normal_out), .pin_out(pin_out), .mask_vec(mask_vec), .tr_ind(tr_ind)
);

// File: tb/atr_switch_test.sv
module atr_switch_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        atr_en = 1'b0;
    logic        fifo_nonempty = 1'b0;
    logic        reg_wr = 1'b0;
    logic [4:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [63:0] normal_out = '0;
    logic [63:0] pin_out;

    int    checks = 0;
    int    fails = 0;
    bit    chk_on = 1'b0;
    bit    done = 1'b0;
    string cur_req = "R1";

    always #2.5 clk = ~clk;

    atr_switch uut (
        .clk(clk), .rst_n(rst_n), .atr_en(atr_en), .fifo_nonempty(fifo_nonempty),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .normal_out(normal_out), .pin_out(pin_out)
    );

    // Reference model, built from the requirements
    logic [15:0] m_mask [4];
    logic [15:0] m_txv  [4];
    logic [15:0] m_rxv  [4];
    int          m_rise, m_fall, m_run;
    logic        m_tr;
    logic [63:0] exp_q;

    function automatic logic [15:0] bank_val(input logic [15:0] nrm, input logic [15:0] msk,
                                             input logic [15:0] sel, input logic en);
        logic [15:0] m;
        m = en ? msk : 16'h0;
        return (nrm & ~m) | (sel & m);
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < 4; s++) begin
                m_mask[s] = '0; m_txv[s] = '0; m_rxv[s] = '0;
            end
            m_rise = 0; m_fall = 0; m_run = 0; m_tr = 1'b0; exp_q = '0;
        end else begin
            int d;
            for (int s = 0; s < 4; s++)
                exp_q[s*16 +: 16] = bank_val(normal_out[s*16 +: 16], m_mask[s],
                                             m_tr ? m_txv[s] : m_rxv[s], atr_en);
            d = m_tr ? m_fall : m_rise;
            if (fifo_nonempty != m_tr) begin
                m_run = m_run + 1;
                if (m_run >= d + 1) begin m_tr = ~m_tr; m_run = 0; end
            end else m_run = 0;
            if (reg_wr) begin
                if (reg_addr == 5'd2) m_rise = int'(reg_wdata);
                if (reg_addr == 5'd3) m_fall = int'(reg_wdata);
                for (int s = 0; s < 4; s++) begin
                    if (int'(reg_addr) == 20 + 3*s) m_mask[s] = reg_wdata;
                    if (int'(reg_addr) == 21 + 3*s) m_txv[s]  = reg_wdata;
                    if (int'(reg_addr) == 22 + 3*s) m_rxv[s]  = reg_wdata;
                end
            end
        end
    end

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    always @(negedge clk) if (chk_on) check(cur_req, pin_out, exp_q);

    task automatic wr(input logic [4:0] a, input logic [15:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic latency(input string req, input logic level, input int expect_n);
        int n = 0;
        fifo_nonempty = level;
        while (pin_out[15:0] != (level ? 16'hFFFF : 16'h0000) && n < 40) begin
            @(negedge clk);
            n++;
        end
        check(req, 64'(n), 64'(expect_n));
    endtask

    initial begin
        #(5.0 * 150000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        if (!done) begin
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        // R1: reset state with busy inputs
        normal_out = 64'hDEAD_BEEF_1234_5678;
        atr_en = 1'b1; fifo_nonempty = 1'b1;
        reg_wr = 1'b1; reg_addr = 5'd20; reg_wdata = 16'hFFFF;
        idle(3);
        check("R1", pin_out, 64'h0);
        reg_wr = 1'b0; atr_en = 1'b0; fifo_nonempty = 1'b0;
        idle(1);
        rst_n = 1'b1;
        idle(1);
        chk_on = 1'b1;

        // R2: switching disabled, masks programmed
        cur_req = "R2";
        for (int s = 0; s < 4; s++) begin
            wr(5'(20 + 3*s), 16'hFFFF);
            wr(5'(21 + 3*s), 16'hA5A5);
        end
        for (int i = 0; i < 300; i++) begin
            normal_out = {$urandom, $urandom};
            if ($urandom_range(5) == 0) fifo_nonempty = ~fifo_nonempty;
            @(negedge clk);
        end

        // R3: random writes across the whole address space
        cur_req = "R3";
        atr_en = 1'b1;
        for (int i = 0; i < 400; i++) begin
            logic [4:0] a = 5'($urandom_range(31));
            normal_out = {$urandom, $urandom};
            if ($urandom_range(4) == 0) fifo_nonempty = ~fifo_nonempty;
            if (a == 5'd2 || a == 5'd3) wr(a, 16'($urandom_range(4)));
            else wr(a, 16'($urandom));
        end

        // R4 / R5: patterns held, FIFO toggling with zero delays
        cur_req = "R5";
        wr(5'd2, 16'd0); wr(5'd3, 16'd0);
        for (int s = 0; s < 4; s++) begin
            wr(5'(20 + 3*s), 16'($urandom));
            wr(5'(21 + 3*s), 16'($urandom));
            wr(5'(22 + 3*s), 16'($urandom));
        end
        for (int i = 0; i < 400; i++) begin
            normal_out = {$urandom, $urandom};
            if ($urandom_range(3) == 0) fifo_nonempty = ~fifo_nonempty;
            if (i == 200) begin cur_req = "R4"; atr_en = 1'b0; end
            if (i == 300) atr_en = 1'b1;
            @(negedge clk);
        end

        // R6 / R7 / R9: directed latencies on bank 0
        cur_req = "R9";
        fifo_nonempty = 1'b0; normal_out = '0;
        wr(5'd20, 16'hFFFF); wr(5'd21, 16'hFFFF); wr(5'd22, 16'h0000);
        wr(5'd2, 16'd0); wr(5'd3, 16'd0);
        idle(4);
        latency("R6", 1'b1, 2);
        idle(3);
        latency("R7", 1'b0, 2);
        wr(5'd2, 16'd3); wr(5'd3, 16'd5);
        idle(3);
        latency("R6", 1'b1, 5);
        idle(3);
        latency("R7", 1'b0, 7);

        // R8: pulses shorter than the pending delay are dropped
        cur_req = "R8";
        wr(5'd2, 16'd5);
        idle(2);
        for (int i = 0; i < 3; i++) begin
            fifo_nonempty = 1'b1; idle(4);
            fifo_nonempty = 1'b0; idle(2);
            check("R8", {48'h0, pin_out[15:0]}, 64'h0);
        end
        latency("R8", 1'b1, 7);
        wr(5'd3, 16'd4);
        idle(2);
        fifo_nonempty = 1'b0; idle(3);
        fifo_nonempty = 1'b1; idle(3);
        check("R8", {48'h0, pin_out[15:0]}, 64'h0000_0000_0000_FFFF);
        latency("R8", 1'b0, 6);

        // R6 / R7: random delays with a random FIFO
        cur_req = "R6";
        for (int i = 0; i < 600; i++) begin
            normal_out = {$urandom, $urandom};
            if (i % 150 == 0) begin
                wr(5'd2, 16'($urandom_range(6)));
                wr(5'd3, 16'($urandom_range(6)));
                cur_req = (i >= 300) ? "R7" : "R6";
            end
            if ($urandom_range(6) == 0) fifo_nonempty = ~fifo_nonempty;
            @(negedge clk);
        end

        chk_on = 1'b0;
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule